// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a parallel flash region and watches the processor's write cycles to it. Each write is framed by an active-low write strobe: the address and the per-sector select lines are taken when the strobe falls, and the data when it rises. The block follows the unlock-prefixed command grammar. From that grammar it issues one-cycle operation requests: word program, multi-sector erase, whole-array erase, erase suspend and erase resume. A separate engine carries out each request and reports the end of the operation with a done pulse and an error flag.

The block also tracks which read view is in force. A registered read-source selector tells the read multiplexer whether to return array data, the device identifier word, or the protection bit of the selected sector. Ordinary array reads need no command cycles. A fast-program mode lets word programs skip the two-write unlock prefix. The erase accumulation window is a parameter in clock cycles.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode is 0 (array read), op_valid is low and rd_src is 0 (array data).
- R2: Only address bits 11:0 take part in decoding, and only data bits 7:0 form a command byte. Every command sequence opens with AAh at offset AAAh, then 55h at offset 554h.
- R3: The sequence prefix followed by 90h at AAAh sets mode 1 (identifier view). In that mode, a read whose offset low byte is 02h gives rd_src 1 and rd_word equal to DEV_ID. A read at 04h with a sector selected gives rd_src 2, and rd_word is 1 if any selected sector is marked in prot_map and 0 otherwise. Outside mode 1, rd_src is 0. rd_src and rd_word follow the read inputs with one cycle of latency.
- R4: A write of F0h at any address returns the decoder to mode 0 from the identifier view and from the error mode 7.
- R5: The prefix followed by A0h at AAAh arms a program. The next write at an even address issues op_code 1 with op_addr taken at the strobe's falling edge and op_data taken at its rising edge. Mode is then 4 (busy) until eng_done.
- R6: An armed program whose data write lands on an odd address issues no request and returns to mode 0.
- R7: A write that does not match the next expected cycle abandons the sequence. A later command byte then has no effect until a complete new prefix has been written.
- R8: The prefix, 80h at AAAh, a second prefix and then 10h at AAAh issue op_code 3 (whole-array erase) and set mode 4.
- R9: The same erase setup ending in 30h with at least one sector select high sets mode 3 (collecting) and starts a window of WIN_CYC cycles. A 30h with no select high is ignored. When the window expires, op_code 2 is issued with op_mask set to the OR of all accepted selects, and mode becomes 5 (erasing).
- R10: Each accepted extra sector restarts the full window.
- R11: In mode 5, B0h at an even address issues op_code 4 and sets mode 6 (suspended). B0h at an odd address, or B0h outside mode 5, has no effect. In mode 6, 30h issues op_code 5 and returns to mode 5.
- R12: eng_done with eng_err high ends the operation in mode 7. In mode 7 every write other than F0h is ignored.
- R13: The prefix followed by 20h at AAAh sets mode 2 (bypass). In mode 2, A0h followed by a write at an even address issues op_code 1 and returns to mode 2 after eng_done. The write pair 90h then 00h returns the decoder to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe, synchronous to clk |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_sel | input | NSEC | Sector selects for the write, active high |
| eng_done | input | 1 | Engine finished the current operation |
| eng_err | input | 1 | Engine finished with an error (qualified by eng_done) |
| rd_ofs | input | 8 | Low byte of the current read address |
| rd_sel | input | NSEC | Sector selects for the current read |
| prot_map | input | NSEC | Protection flag per sector |
| mode | output | 3 | Current mode code |
| op_valid | output | 1 | One-cycle operation request |
| op_code | output | 3 | 1 program, 2 sector erase, 3 whole erase, 4 suspend, 5 resume |
| op_addr | output | AW | Program address |
| op_data | output | DW | Program data |
| op_mask | output | NSEC | Sectors to erase |
| rd_src | output | 2 | 0 array, 1 identifier, 2 protection |
| rd_word | output | DW | Identifier or protection word |

## Verification
The bench restarts the erase window halfway through and checks that no erase starts at the first deadline. A design that ignored the restart would launch early and lose the later sector from the mask. It changes the address between the strobe's fall and rise, so a design that latched the address late would report the wrong program address. It sends a stray write inside a prefix and then the command byte alone, which a design that does not abandon partial sequences would obey. It also sends suspend bytes at an odd address and outside an erase, and ordinary writes in error mode; a decoder that accepted any of these would change mode or raise a request.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam logic [11:0] OFS_A = 12'hAAA;
  localparam logic [11:0] OFS_B = 12'h554;
  localparam logic [7:0] C_UNL1 = 8'hAA;
  localparam logic [7:0] C_UNL2 = 8'h55;
  localparam logic [7:0] C_IDRD = 8'h90;
  localparam logic [7:0] C_PROG = 8'hA0;
  localparam logic [7:0] C_ERST = 8'h80;
  localparam logic [7:0] C_BYPS = 8'h20;
  localparam logic [7:0] C_SECT = 8'h30;
  localparam logic [7:0] C_BULK = 8'h10;
  localparam logic [7:0] C_SUSP = 8'hB0;
  localparam logic [7:0] C_RSET = 8'hF0;
  localparam logic [7:0] C_BXIT = 8'h00;

  typedef enum logic [2:0] {
    MD_ARRAY = 3'd0, MD_ID = 3'd1, MD_BYPASS = 3'd2, MD_EWIN = 3'd3,
    MD_BUSY = 3'd4, MD_ERASING = 3'd5, MD_SUSP = 3'd6, MD_ERROR = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_SECT = 3'd2, OP_BULK = 3'd3,
    OP_SUSP = 3'd4, OP_RESUME = 3'd5
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_U1, S_U2, S_ID, S_PARM, S_E1, S_E2, S_E3, S_EWIN,
    S_BUSY, S_ERASE, S_SUSP, S_BYP, S_BARM, S_BEXIT, S_BBUSY, S_ERR
  } st_e;

  function automatic mode_e mode_of(st_e s);
    case (s)
      S_ID:                   return MD_ID;
      S_BYP, S_BARM, S_BEXIT: return MD_BYPASS;
      S_EWIN:                 return MD_EWIN;
      S_BUSY, S_BBUSY:        return MD_BUSY;
      S_ERASE:                return MD_ERASING;
      S_SUSP:                 return MD_SUSP;
      S_ERR:                  return MD_ERROR;
      default:                return MD_ARRAY;
    endcase
  endfunction
endpackage

// File: rtl/fcd_wr_capture.sv
module fcd_wr_capture #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NSEC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data,
  input  logic [NSEC-1:0] sel,
  output logic            ev,
  output logic [AW-1:0]   ev_addr,
  output logic [DW-1:0]   ev_data,
  output logic [NSEC-1:0] ev_sel
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b1;
      ev      <= 1'b0;
      ev_addr <= '0;
      ev_data <= '0;
      ev_sel  <= '0;
    end else begin
      wr_q <= wr_n;
      ev   <= 1'b0;
      if (wr_q && !wr_n) begin   // strobe falls: address and selects
        ev_addr <= addr;
        ev_sel  <= sel;
      end
      if (!wr_q && wr_n) begin   // strobe rises: data, cycle complete
        ev_data <= data;
        ev      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcd_erase_window.sv
module fcd_erase_window #(
  parameter int WIN_CYC = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYC + 1);
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (restart) begin
      cnt <= CW'(WIN_CYC - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux #(
  parameter int DW = 16,
  parameter int NSEC = 8,
  parameter logic [DW-1:0] DEV_ID = 16'h22E7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_id,
  input  logic [7:0]      rd_ofs,
  input  logic [NSEC-1:0] rd_sel,
  input  logic [NSEC-1:0] prot_map,
  output logic [1:0]      rd_src,
  output logic [DW-1:0]   rd_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src  <= 2'd0;
      rd_word <= '0;
    end else if (in_id && rd_ofs == 8'h02) begin
      rd_src  <= 2'd1;
      rd_word <= DEV_ID;
    end else if (in_id && rd_ofs == 8'h04 && |rd_sel) begin
      rd_src  <= 2'd2;
      rd_word <= DW'(|(rd_sel & prot_map));
    end else begin
      rd_src  <= 2'd0;
      rd_word <= '0;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NSEC = 8,
  parameter int WIN_CYC = 4000,
  parameter logic [DW-1:0] DEV_ID = 16'h22E7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_n,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSEC-1:0] wr_sel,
  input  logic            eng_done,
  input  logic            eng_err,
  input  logic [7:0]      rd_ofs,
  input  logic [NSEC-1:0] rd_sel,
  input  logic [NSEC-1:0] prot_map,
  output logic [2:0]      mode,
  output logic            op_valid,
  output logic [2:0]      op_code,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_data,
  output logic [NSEC-1:0] op_mask,
  output logic [1:0]      rd_src,
  output logic [DW-1:0]   rd_word
);
  logic            ev;
  logic [AW-1:0]   ev_addr;
  logic [DW-1:0]   ev_data;
  logic [NSEC-1:0] ev_sel;
  logic            win_rst, win_exp;
  st_e             st, nxt;
  op_e             nop;
  logic [NSEC-1:0] mask, nmask;

  fcd_wr_capture #(.AW(AW), .DW(DW), .NSEC(NSEC)) u_cap (
    .clk(clk), .rst(rst), .wr_n(wr_n), .addr(wr_addr), .data(wr_data),
    .sel(wr_sel), .ev(ev), .ev_addr(ev_addr), .ev_data(ev_data), .ev_sel(ev_sel));

  fcd_erase_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .restart(win_rst), .expire(win_exp));

  fcd_read_mux #(.DW(DW), .NSEC(NSEC), .DEV_ID(DEV_ID)) u_rmux (
    .clk(clk), .rst(rst), .in_id(st == S_ID), .rd_ofs(rd_ofs), .rd_sel(rd_sel),
    .prot_map(prot_map), .rd_src(rd_src), .rd_word(rd_word));

  wire [7:0] c    = ev_data[7:0];
  wire       at_a = ev_addr[11:0] == OFS_A;
  wire       at_b = ev_addr[11:0] == OFS_B;
  wire       even = !ev_addr[0];
  wire       sec_add = ev && c == C_SECT && |ev_sel;

  always_comb begin
    nxt = st; nop = OP_NONE; win_rst = 1'b0; nmask = mask;
    case (st)
      S_IDLE:  if (ev && c == C_UNL1 && at_a) nxt = S_U1;
      S_U1:    if (ev) nxt = (c == C_UNL2 && at_b) ? S_U2 : S_IDLE;
      S_U2:    if (ev) begin
                 nxt = S_IDLE;
                 if (at_a) begin
                   case (c)
                     C_IDRD:  nxt = S_ID;
                     C_PROG:  nxt = S_PARM;
                     C_ERST:  nxt = S_E1;
                     C_BYPS:  nxt = S_BYP;
                     default: nxt = S_IDLE;
                   endcase
                 end
               end
      S_ID:    if (ev && c == C_RSET) nxt = S_IDLE;
      S_PARM:  if (ev) begin
                 if (even) begin nop = OP_PROG; nxt = S_BUSY; end
                 else nxt = S_IDLE;
               end
      S_E1:    if (ev) nxt = (c == C_UNL1 && at_a) ? S_E2 : S_IDLE;
      S_E2:    if (ev) nxt = (c == C_UNL2 && at_b) ? S_E3 : S_IDLE;
      S_E3:    if (ev) begin
                 nxt = S_IDLE;
                 if (c == C_BULK && at_a) begin
                   nop = OP_BULK; nxt = S_BUSY;
                 end else if (sec_add) begin
                   nmask = ev_sel; win_rst = 1'b1; nxt = S_EWIN;
                 end
               end
      S_EWIN:  if (sec_add) begin
                 nmask = mask | ev_sel; win_rst = 1'b1;
               end else if (win_exp) begin
                 nop = OP_SECT; nxt = S_ERASE;
               end
      S_BUSY:  if (eng_done) nxt = eng_err ? S_ERR : S_IDLE;
      S_ERASE: if (eng_done) nxt = eng_err ? S_ERR : S_IDLE;
               else if (ev && c == C_SUSP && even) begin
                 nop = OP_SUSP; nxt = S_SUSP;
               end
      S_SUSP:  if (ev && c == C_SECT) begin nop = OP_RESUME; nxt = S_ERASE; end
      S_BYP:   if (ev) begin
                 if (c == C_PROG)      nxt = S_BARM;
                 else if (c == C_IDRD) nxt = S_BEXIT;
               end
      S_BARM:  if (ev) begin
                 if (even) begin nop = OP_PROG; nxt = S_BBUSY; end
                 else nxt = S_BYP;
               end
      S_BEXIT: if (ev) nxt = (c == C_BXIT) ? S_IDLE : S_BYP;
      S_BBUSY: if (eng_done) nxt = eng_err ? S_ERR : S_BYP;
      S_ERR:   if (ev && c == C_RSET) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; mode <= MD_ARRAY; mask <= '0;
      op_valid <= 1'b0; op_code <= OP_NONE;
      op_addr <= '0; op_data <= '0; op_mask <= '0;
    end else begin
      st       <= nxt;
      mode     <= mode_of(nxt);
      mask     <= nmask;
      op_valid <= nop != OP_NONE;
      op_code  <= nop;
      if (nop != OP_NONE) begin
        op_addr <= ev_addr;
        op_data <= ev_data;
        op_mask <= (nop == OP_SECT) ? mask : '0;
      end
    end
  end
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int AW = 20,
  parameter int NSEC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      mode,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic [AW-1:0]   op_addr,
  input logic [NSEC-1:0] op_mask
);
  p_sect_after_window_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd2) |-> ($past(mode) == 3'd3 && op_mask != '0 && mode == 3'd5));

  p_prog_even_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd1) |-> (!op_addr[0] && mode == 3'd4));

  p_op_single_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);

  p_suspend_src_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd4) |-> ($past(mode) == 3'd5 && mode == 3'd6));

  p_resume_src_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd5) |-> ($past(mode) == 3'd6 && mode == 3'd5));

  p_error_exit_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 3'd7 && mode != 3'd7) |-> mode == 3'd0);

  p_bulk_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd3) |-> mode == 3'd4);
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW), .NSEC(NSEC)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .op_valid(op_valid), .op_code(op_code),
  .op_addr(op_addr), .op_mask(op_mask));

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PER = 10;
  localparam int WIN = 40;
  localparam logic [15:0] IDW = 16'h22E7;

  logic        clk = 1'b0, rst = 1'b1, wr_n = 1'b1, eng_done = 1'b0, eng_err = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  wr_sel = '0, rd_sel = '0, prot_map = '0, rd_ofs = '0;
  logic [2:0]  mode, op_code;
  logic        op_valid;
  logic [19:0] op_addr;
  logic [15:0] op_data, rd_word;
  logic [7:0]  op_mask;
  logic [1:0]  rd_src;
  int total = 0, bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  flash_cmd_decoder #(.AW(20), .DW(16), .NSEC(8), .WIN_CYC(WIN), .DEV_ID(IDW)) u0 (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_sel(wr_sel), .eng_done(eng_done), .eng_err(eng_err), .rd_ofs(rd_ofs),
    .rd_sel(rd_sel), .prot_map(prot_map), .mode(mode), .op_valid(op_valid),
    .op_code(op_code), .op_addr(op_addr), .op_data(op_data), .op_mask(op_mask),
    .rd_src(rd_src), .rd_word(rd_word));

  typedef struct packed {
    logic [19:0] a; logic [15:0] d; logic [7:0] s;
    logic [2:0] m; logic v; logic [2:0] c;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [0:NV-1] = '{
    '{20'h0FAAA, 16'h00AA, 8'h00, 3'd0, 1'b0, 3'd0},  // R2 upper bits ignored
    '{20'h3F554, 16'hFF55, 8'h00, 3'd0, 1'b0, 3'd0},  // R2 upper data bits ignored
    '{20'h00AAA, 16'h0090, 8'h00, 3'd1, 1'b0, 3'd0},  // R3 identifier view
    '{20'h00123, 16'h0077, 8'h00, 3'd1, 1'b0, 3'd0},
    '{20'h00000, 16'h00F0, 8'h00, 3'd0, 1'b0, 3'd0},  // R4
    '{20'h00AAA, 16'h00AA, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00554, 16'h0055, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00AAA, 16'h0020, 8'h00, 3'd2, 1'b0, 3'd0},  // R13 bypass
    '{20'h00010, 16'h00A0, 8'h00, 3'd2, 1'b0, 3'd0},
    '{20'h00100, 16'hBEEF, 8'h00, 3'd4, 1'b1, 3'd1},  // R13 program
    '{20'h00000, 16'h0090, 8'h00, 3'd2, 1'b0, 3'd0},
    '{20'h00000, 16'h0000, 8'h00, 3'd0, 1'b0, 3'd0},  // R13 exit
    '{20'h00AAA, 16'h00AA, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00555, 16'h0055, 8'h00, 3'd0, 1'b0, 3'd0},  // R7 wrong offset
    '{20'h00AAA, 16'h0090, 8'h00, 3'd0, 1'b0, 3'd0},  // R7 no ID entry
    '{20'h00AAA, 16'h00AA, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00554, 16'h0055, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00AAA, 16'h0080, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00AAA, 16'h00AA, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00554, 16'h0055, 8'h00, 3'd0, 1'b0, 3'd0},
    '{20'h00AAA, 16'h0010, 8'h00, 3'd4, 1'b1, 3'd3},  // R8 bulk
    '{20'h00000, 16'h00B0, 8'h00, 3'd0, 1'b0, 3'd0}   // R11 B0 outside erase
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr2(input logic [19:0] af, input logic [19:0] ar, input logic [15:0] d, input logic [7:0] s);
    wr_addr = af; wr_sel = s; wr_data = 16'hDEAD; wr_n = 1'b0;
    @(negedge clk);
    wr_addr = ar; wr_data = d; wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic [7:0] s);
    wr2(a, a, d, s);
  endtask

  task automatic prefix();
    wr(20'h00AAA, 16'h00AA, 8'h00);
    wr(20'h00554, 16'h0055, 8'h00);
  endtask

  task automatic done_pulse(input logic e);
    eng_err = e; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mode == 3'd0, "R1 mode", 32'(mode), 0);
    check(op_valid == 1'b0, "R1 op_valid", 32'(op_valid), 0);
    check(rd_src == 2'd0, "R1 rd_src", 32'(rd_src), 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d, VEC[i].s);
      check(mode == VEC[i].m, $sformatf("R2/R7/R13 vec%0d mode", i), 32'(mode), 32'(VEC[i].m));
      check(op_valid == VEC[i].v, $sformatf("R5/R8 vec%0d op_valid", i), 32'(op_valid), 32'(VEC[i].v));
      if (VEC[i].v)
        check(op_code == VEC[i].c, $sformatf("R8/R13 vec%0d op_code", i), 32'(op_code), 32'(VEC[i].c));
      if (VEC[i].m == 3'd4) done_pulse(1'b0);
    end

    // R3 read views
    prefix(); wr(20'h00AAA, 16'h0090, 8'h00);
    rd_ofs = 8'h02; @(negedge clk);
    check(rd_src == 2'd1 && rd_word == IDW, "R3 id word", 32'(rd_word), 32'(IDW));
    rd_ofs = 8'h04; rd_sel = 8'h04; prot_map = 8'h04; @(negedge clk);
    check(rd_src == 2'd2 && rd_word == 16'd1, "R3 protected", 32'(rd_word), 1);
    rd_sel = 8'h02; @(negedge clk);
    check(rd_src == 2'd2 && rd_word == 16'd0, "R3 unprotected", 32'(rd_word), 0);
    wr(20'h12345, 16'h00F0, 8'h00);
    check(mode == 3'd0, "R4 exit id", 32'(mode), 0);
    rd_ofs = 8'h02; @(negedge clk);
    check(rd_src == 2'd0, "R3 array outside id", 32'(rd_src), 0);
    rd_sel = 8'h00;

    // R5 address from falling edge, data from rising edge
    prefix(); wr(20'h00AAA, 16'h00A0, 8'h00);
    wr2(20'h04440, 20'h08881, 16'h1234, 8'h00);
    check(op_valid && op_code == 3'd1, "R5 program op", 32'(op_code), 1);
    check(op_addr == 20'h04440, "R5 fall address", 32'(op_addr), 32'h04440);
    check(op_data == 16'h1234, "R5 rise data", 32'(op_data), 32'h1234);
    check(mode == 3'd4, "R5 busy", 32'(mode), 4);
    done_pulse(1'b0);
    check(mode == 3'd0, "R5 done", 32'(mode), 0);

    // R6 odd program address
    prefix(); wr(20'h00AAA, 16'h00A0, 8'h00);
    wr(20'h00101, 16'h5555, 8'h00);
    check(!op_valid && mode == 3'd0, "R6 odd address", 32'(mode), 0);

    // R9 / R10 sector erase window
    prefix(); wr(20'h00AAA, 16'h0080, 8'h00); prefix();
    wr(20'h10000, 16'h0030, 8'h01);
    check(mode == 3'd3, "R9 collecting", 32'(mode), 3);
    k = 0;
    repeat (20) begin @(negedge clk); if (op_valid) k++; end
    wr(20'h20000, 16'h0030, 8'h00);
    check(mode == 3'd3 && !op_valid, "R9 no-select ignored", 32'(mode), 3);
    wr(20'h30000, 16'h0030, 8'h08);
    k = 0;
    for (int j = 1; j <= 3 * WIN; j++) begin
      @(negedge clk);
      if (op_valid) begin k = j; break; end
    end
    check(k >= WIN - 1 && k <= WIN + 1, "R10 window restart", 32'(k), 32'(WIN));
    check(op_code == 3'd2 && op_mask == 8'h09, "R9 erase mask", 32'(op_mask), 32'h09);
    check(mode == 3'd5, "R9 erasing", 32'(mode), 5);

    // R11 suspend / resume
    wr(20'h00001, 16'h00B0, 8'h00);
    check(!op_valid && mode == 3'd5, "R11 odd suspend ignored", 32'(mode), 5);
    wr(20'h00000, 16'h00B0, 8'h00);
    check(op_valid && op_code == 3'd4 && mode == 3'd6, "R11 suspend", 32'(op_code), 4);
    wr(20'h00000, 16'h0030, 8'h00);
    check(op_valid && op_code == 3'd5 && mode == 3'd5, "R11 resume", 32'(op_code), 5);

    // R12 error, R4 recovery
    done_pulse(1'b1);
    check(mode == 3'd7, "R12 error mode", 32'(mode), 7);
    wr(20'h00AAA, 16'h00AA, 8'h00);
    wr(20'h00554, 16'h0055, 8'h00);
    check(mode == 3'd7 && !op_valid, "R12 writes ignored", 32'(mode), 7);
    wr(20'h00000, 16'h00F0, 8'h00);
    check(mode == 3'd0, "R4 error exit", 32'(mode), 0);

    summary();
  end
endmodule